// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A single-clock synchronous SRAM with a 36-bit word split into four 9-bit byte lanes (8 data bits plus a parity bit each). Every control, address and data input is captured on the rising clock edge. An access begins on one of two address strobes and may then run through a 2-bit burst counter. The counter steps in linear (wrapping add) order or in interleaved (XOR) order, as a mode pin selects.

The processor-side strobe always begins a read. The controller-side strobe begins a read or a write, or it deselects the device. Writes merge per lane under a global-write input or under a byte-write enable with per-lane enables. Read data is registered. The output-enable input and the snooze input gate the data-valid output without waiting for a clock edge. The array depth is a parameter.

Top module: `sburst_sram`

## Requirements
- R1: After reset `dout_en` is 0, the device is deselected and the burst counter is cleared, so burst cycles do nothing until a strobe loads an address.
- R2: With `seq_mode`=0 the order is linear: the low two address bits of access k (k=0..3) are (loaded low bits + k) mod 4, and the upper address bits stay fixed.
- R3: With `seq_mode`=1 the order is interleaved: the low two address bits of access k are the loaded low bits XOR k.
- R4: `adsp_n`=0 with `cs_n`=0 loads `addr`, clears the counter and performs a read at that address, whatever the write controls and `adsc_n` show. With `cs_n`=1, `adsp_n` is ignored.
- R5: `adsc_n`=0 with `cs_n`=0 (and `adsp_n`=1) loads `addr` and performs a read or a write as the write controls decide. `adsc_n`=0 with `cs_n`=1 deselects the device and drives `dout_en` to 0.
- R6: On edges where neither strobe loads an address, `cs_n` has no effect.
- R7: On a burst edge with no load, `adv_n`=0 steps the counter to the next address and `adv_n`=1 repeats the current address (a wait state).
- R8: `gw_n`=0 writes all four lanes. Otherwise `bwe_n`=0 writes each lane i whose `bw_n[i]`=0, where lane i is `din[9i+8:9i]`. Otherwise, including `bwe_n`=1 with some `bw_n` low, the cycle is a read.
- R9: After a processor-side start, a write on the next edge with `adv_n`=1 goes to the loaded address.
- R10: While `zz`=1 all other inputs are ignored: no state changes, the array keeps its contents, and `dout_en` is 0.
- R11: Read data appears on `dout` one clock after the address is used. `dout_en` is 1 only if the last registered cycle was a read, `oe_n`=0 (without waiting for a clock), the device is selected and `zz`=0. After a write edge, `dout_en` is 0 whatever `oe_n` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | External address |
| cs_n | input | 1 | Chip select, active low |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not clocked |
| zz | input | 1 | Snooze, active high |
| seq_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dout_en | output | 1 | Data-out valid/drive enable |

## Verification
Two pairs of events can land in one cycle. In the first, a strobe and write controls arrive on the same edge. In the second, snooze arrives in the middle of a burst. The bench drives `adsp_n` low together with `gw_n` low and junk data. It then requires the old word to be read and the array to be left untouched, and it requires the following wait-state write to merge only the enabled lanes into the loaded address. The bench also raises `zz` on an edge that carries a full write and a new strobe. It then requires `dout_en` low, the target word unchanged, and the burst to resume at the next address when snooze drops.

// File: rtl/sburst_sram.sv
module sburst_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [$clog2(DEPTH)-1:0]          addr,
  input  logic                              cs_n,
  input  logic                              adsp_n,
  input  logic                              adsc_n,
  input  logic                              adv_n,
  input  logic                              gw_n,
  input  logic                              bwe_n,
  input  logic [LANES-1:0]                  bw_n,
  input  logic                              oe_n,
  input  logic                              zz,
  input  logic                              seq_mode,
  input  logic [LANES*LANE_W-1:0]           din,
  output logic [LANES*LANE_W-1:0]           dout,
  output logic                              dout_en
);
  localparam int AW = $clog2(DEPTH);
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q, cnt_nx, low_bits;
  logic             sel_q, rd_q;
  logic [DW-1:0]    q_q;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    eff;

  wire load_p = !adsp_n && !cs_n;
  wire load_c = !adsc_n && !cs_n && adsp_n;
  wire desel  = !adsc_n && cs_n;
  wire burst  = sel_q && adsc_n && !load_p;
  wire load   = load_p || load_c;

  assign cnt_nx   = adv_n ? cnt_q : cnt_q + 2'd1;
  assign low_bits = seq_mode ? (base_q[1:0] ^ cnt_nx) : (base_q[1:0] + cnt_nx);
  assign eff      = load ? addr : {base_q[AW-1:2], low_bits};
  assign lane_we  = !gw_n ? '1 : (!bwe_n ? ~bw_n : '0);

  wire wr_cyc = (load_c || burst) && (|lane_we);
  wire rd_cyc = load_p || ((load_c || burst) && !(|lane_we));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      q_q    <= '0;
    end else if (!zz) begin
      if (desel) begin
        sel_q <= 1'b0;
      end else if (load) begin
        base_q <= addr;
        cnt_q  <= '0;
        sel_q  <= 1'b1;
      end else if (burst) begin
        cnt_q <= cnt_nx;
      end
      rd_q <= rd_cyc && !desel;
      if (rd_cyc && !desel) q_q <= mem[eff];
    end
  end

  always_ff @(posedge clk) begin
    if (!zz && wr_cyc && !desel) begin
      for (int l = 0; l < LANES; l++)
        if (lane_we[l]) mem[eff][l*LANE_W +: LANE_W] <= din[l*LANE_W +: LANE_W];
    end
  end

  assign dout    = q_q;
  assign dout_en = rd_q && !oe_n && sel_q && !zz;

  p_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> !dout_en);

  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !cs_n && (!adsp_n || !adsc_n)) |=> (cnt_q == 2'd0 && sel_q));

  p_proc_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && !cs_n && !adsp_n) |=> rd_q);

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && cs_n && !adsc_n) |=> !dout_en);

  p_adv_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && sel_q && adsc_n && (adsp_n || cs_n) && !adv_n) |=> cnt_q == $past(cnt_q) + 2'd1);

  p_adv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && sel_q && adsc_n && (adsp_n || cs_n) && adv_n) |=> $stable(cnt_q));

  p_snooze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ($stable(cnt_q) && $stable(sel_q) && $stable(base_q) && $stable(q_q)));

  p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && sel_q && adsc_n && (adsp_n || cs_n) && !gw_n) |=> !dout_en);
endmodule

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr;
  logic cs_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n, zz, seq_mode;
  logic [3:0] bw_n;
  logic [DW-1:0] din, dout;
  logic dout_en;
  logic [DW-1:0] refm [256];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sburst_sram u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .adsp_n(adsp_n),
    .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .zz(zz), .seq_mode(seq_mode), .din(din), .dout(dout), .dout_en(dout_en));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic idle();
    cs_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1;
    bw_n = 4'hF; oe_n = 0; zz = 0; din = '0;
  endtask

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] b, int k, logic m);
    logic [1:0] lo = m ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] pat(int i, int s);
    return DW'(36'h9_0F0F_3C3C ^ (i * 36'h0_1234_567) ^ (s * 36'h5_5000_0011));
  endfunction

  task automatic rd_start(logic [AW-1:0] a, string req);
    idle(); adsc_n = 0; addr = a; tick();
    chk(req, dout_en, 1); chk(req, dout, refm[a]);
    adsc_n = 1;
  endtask

  task automatic t_reset();
    idle(); adv_n = 0;
    tick();
    chk("R1", dout_en, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 64; i++) begin
      idle(); adsc_n = 0; addr = AW'(i); gw_n = 0; din = pat(i, 0);
      tick(); refm[i] = din;
    end
    idle();
  endtask

  task automatic t_burst(logic m, logic [AW-1:0] wb, logic [AW-1:0] rb, string req);
    idle(); seq_mode = m;
    adsc_n = 0; addr = wb; gw_n = 0;
    for (int k = 0; k < 4; k++) begin
      din = pat(k, 7 + int'(m));
      tick();
      refm[nxt(wb, k, m)] = din;
      adsc_n = 1; adv_n = 0;
    end
    idle(); seq_mode = m;
    adsc_n = 0; addr = rb;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(req, dout, refm[nxt(rb, k, m)]);
      adsc_n = 1; adv_n = 0;
    end
    idle();
  endtask

  task automatic t_proc();
    logic [DW-1:0] d = 36'hA_BCDE_F012;
    idle(); seq_mode = 0;
    adsp_n = 0; addr = 30; gw_n = 0; adsc_n = 0; din = 36'hF_FFFF_FFFF;
    tick();
    chk("R4", dout_en, 1); chk("R4", dout, refm[30]);
    idle(); adv_n = 1; bwe_n = 0; bw_n = 4'b1010; din = d;
    tick();
    chk("R11", dout_en, 0);
    refm[30][8:0] = d[8:0]; refm[30][26:18] = d[26:18];
    rd_start(30, "R9");
    rd_start(20, "R4");
    adsp_n = 0; cs_n = 1; addr = 60; adv_n = 1;
    tick();
    chk("R4", dout, refm[20]);
    idle();
  endtask

  task automatic t_desel();
    rd_start(16, "R5");
    cs_n = 1; adv_n = 0;
    tick();
    chk("R6", dout_en, 1); chk("R6", dout, refm[17]);
    idle(); adsc_n = 0; cs_n = 1;
    tick();
    chk("R5", dout_en, 0);
    idle(); adv_n = 0;
    tick();
    chk("R5", dout_en, 0);
    idle();
  endtask

  task automatic t_adv();
    seq_mode = 0;
    rd_start(12, "R7");
    adv_n = 1; tick(); chk("R7", dout, refm[12]);
    adv_n = 0; tick(); chk("R7", dout, refm[13]);
    adv_n = 1; tick(); chk("R7", dout, refm[13]);
    idle();
  endtask

  task automatic t_lanes();
    seq_mode = 0;
    rd_start(40, "R8");
    bwe_n = 1; bw_n = 4'h0; adv_n = 1; din = '0;
    tick();
    chk("R8", dout_en, 1); chk("R8", dout, refm[40]);
    idle(); adsc_n = 0; addr = 41; bwe_n = 0; bw_n = 4'b0111; din = 36'h1_2345_6789;
    tick();
    refm[41][35:27] = din[35:27];
    idle(); adsc_n = 0; addr = 42; gw_n = 0; bwe_n = 1; bw_n = 4'hF; din = 36'h7_7777_0000;
    tick();
    refm[42] = din;
    rd_start(41, "R8");
    rd_start(42, "R8");
    idle();
  endtask

  task automatic t_snooze();
    seq_mode = 0;
    rd_start(8, "R10");
    zz = 1; adsc_n = 0; addr = 50; gw_n = 0; din = '0; adv_n = 0;
    tick();
    chk("R10", dout_en, 0);
    idle(); adv_n = 0;
    tick();
    chk("R10", dout, refm[9]);
    rd_start(50, "R10");
    idle();
  endtask

  task automatic t_oe();
    rd_start(5, "R11");
    oe_n = 1; #1; chk("R11", dout_en, 0);
    oe_n = 0; #1; chk("R11", dout_en, 1);
    idle();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(); seq_mode = 0; addr = '0;
    repeat (2) @(posedge clk);
    #2 chk("R1", dout_en, 0);
    rst_n = 1;
    t_reset();
    t_fill();
    t_burst(0, 8'd1, 8'd2, "R2");
    t_burst(1, 8'd5, 8'd6, "R3");
    t_proc();
    t_desel();
    t_adv();
    t_lanes();
    t_snooze();
    t_oe();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule